// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a 32-bit count of elapsed microseconds for a chip whose reference clock may run at one of several rates (12, 13, 19.2 or 26 MHz, among others). A programmable fractional prescaler turns the reference clock into a tick that lasts one clock cycle. The tick averages exactly 1 MHz even when the clock-to-microsecond ratio is not a whole number. The tick advances the count and is also driven out on `usec_tick`, so that neighbouring countdown timers can share the same time base.

Software reaches the block through a small register port. Requests use valid/ready. A read returns its data on a response channel that also uses valid/ready. While a read response is stalled (`rsp_valid` high and `rsp_ready` low), the block stops accepting requests (`req_ready` low) and holds the response unchanged. A write completes when it is accepted and produces no response.

The prescaler setting holds a dividend M and a divisor N. Over every N reference cycles the block produces exactly M ticks. For example, 5/96 at 19.2 MHz, 1/12 at 12 MHz and 1/26 at 26 MHz each give 1 MHz.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0, the configuration register reads 0x0000000B, `usec_tick` is low and `rsp_valid` is low.
- R2: Configuration bits [7:0] hold N-1 (divisor minus one) and bits [15:8] hold M-1 (dividend minus one). A write stores wdata[15:0], and a read returns those 16 bits with bits [31:16] reading as zero.
- R3: With M < N, number each edge after a configuration write k (the write edge itself is k=0). `usec_tick` is high in the cycle after edge k exactly when floor(k·M/N) > floor((k-1)·M/N).
- R4: The tick rate is exact on average. Setting 0x045F (M=5, N=96) yields exactly 50 ticks in 960 cycles following the write.
- R5: The count rises by exactly one on each edge that raises a tick, and it changes on no other edge unless it is written.
- R6: The count wraps from 0xFFFFFFFF to 0x00000000 with no other effect.
- R7: A write to offset 0x10 loads the count. The load takes priority over a tick on the same edge, and it does not disturb the prescaler phase.
- R8: A write to offset 0x14 restarts the prescaler phase. No tick occurs on the write edge, and for 0x045F the first tick follows edge k=20.
- R9: A read of offset 0x10 returns the count and a read of 0x14 returns the configuration. Reads of any other offset return 0, and writes to any other offset change nothing.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A read response carries the value at the edge where the read was accepted, and it stays valid and unchanged while `rsp_ready` is low.
- R11: With M >= N, `usec_tick` is high on every cycle except the one that follows a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| usec_tick | output | 1 | One-cycle microsecond tick enable |

## Verification
The hardest conditions to reach are a prescaler phase several periods deep, hit by a count write or a new configuration on exactly the edge where a tick is due, and a read response stalled across a tick. A bench model tracks the edge index since the last configuration write and predicts every tick from the floor rule. Random traffic uses small random ratios, including M >= N, with many short periods, and throttles `rsp_ready`. This makes those collisions frequent while every cycle's tick and every read response is compared.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  parameter int OFS_COUNT = 'h10;
  parameter int OFS_CFG   = 'h14;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CFG   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/usec_frac_tick.sv
// Fractional tick generator: M ticks out of every N clock cycles.
module usec_frac_tick #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [FIELD_W-1:0] num_m1,
  input  logic [FIELD_W-1:0] den_m1,
  output logic               tick_o
);
  localparam int SUM_W = FIELD_W + 2;

  logic [SUM_W-1:0] num, den, acc_q, sum, acc_nx;
  logic             hit;

  assign num = SUM_W'(num_m1) + SUM_W'(1);
  assign den = SUM_W'(den_m1) + SUM_W'(1);
  assign sum = acc_q + num;

  always_comb begin
    if (num >= den) begin
      hit    = 1'b1;
      acc_nx = '0;
    end else if (sum >= den) begin
      hit    = 1'b1;
      acc_nx = sum - den;
    end else begin
      hit    = 1'b0;
      acc_nx = sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (cfg_load) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_nx;
      tick_o <= hit;
    end
  end
endmodule

// File: rtl/usec_up_counter.sv
// Microsecond up counter with load priority over increment.
module usec_up_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (load_i) count_o <= load_val;
    else if (inc_i)  count_o <= count_o + CNT_W'(1);
  end
endmodule

// File: rtl/usec_reg_port.sv
// Register port: request/response handshake, decode, configuration register.
module usec_reg_port
  import usec_timebase_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [2*FIELD_W-1:0] CFG_RST = 'h000b
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [CNT_W-1:0]     count_i,
  output logic [2*FIELD_W-1:0] cfg_q,
  output logic                 cfg_load,
  output logic                 cnt_load,
  output logic [CNT_W-1:0]     cnt_wdata
);
  localparam int CFG_W = 2 * FIELD_W;

  reg_sel_e          sel;
  logic              accept, rd_acc;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    if (req_addr == ADDR_W'(OFS_COUNT))    sel = SEL_COUNT;
    else if (req_addr == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
    else                                   sel = SEL_NONE;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign cfg_load  = accept && req_write && (sel == SEL_CFG);
  assign cnt_load  = accept && req_write && (sel == SEL_COUNT);
  assign cnt_wdata = req_wdata[CNT_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_COUNT: rd_val = DATA_W'(count_i);
      SEL_CFG:   rd_val = DATA_W'(cfg_q);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= CFG_RST;
    else if (cfg_load) cfg_q <= req_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usec_timebase.sv
// Top: fractional microsecond timebase.
module usec_timebase #(
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [2*FIELD_W-1:0] CFG_RST = 'h000b
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              usec_tick
);
  logic [2*FIELD_W-1:0] cfg_w;
  logic                 cfg_load_w, cnt_load_w;
  logic [CNT_W-1:0]     cnt_wdata_w, count_w;

  usec_reg_port #(
    .FIELD_W(FIELD_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .CFG_RST(CFG_RST)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .count_i   (count_w),
    .cfg_q     (cfg_w),
    .cfg_load  (cfg_load_w),
    .cnt_load  (cnt_load_w),
    .cnt_wdata (cnt_wdata_w)
  );

  usec_frac_tick #(.FIELD_W(FIELD_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load_w),
    .num_m1   (cfg_w[2*FIELD_W-1:FIELD_W]),
    .den_m1   (cfg_w[FIELD_W-1:0]),
    .tick_o   (usec_tick)
  );

  // Counter advances on the same edge that raises usec_tick.
  usec_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (u_tick.hit && !cfg_load_w),
    .load_i   (cnt_load_w),
    .load_val (cnt_wdata_w),
    .count_o  (count_w)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
// Checker bound to usec_timebase.
module usec_timebase_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usec_tick,
  input logic [CNT_W-1:0]  count,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              cfg_load,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata
);
  // R5, R6: tick edge advances count by one (modulo wrap)
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (usec_tick && !$past(cnt_load)) |->
      count == ($past(count) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R5: no tick, no write -> count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!usec_tick && !$past(cnt_load)) |-> count == $past(count));

  // R7: a count write wins
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_load) |-> count == $past(cnt_wdata));

  // R8: configuration write leaves the next cycle tick-free
  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !usec_tick);

  // R10: stalled response holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind usec_timebase usec_timebase_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .usec_tick (usec_tick),
  .count     (count_w),
  .cnt_load  (cnt_load_w),
  .cnt_wdata (cnt_wdata_w),
  .cfg_load  (cfg_load_w),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, rsp_ready;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid, usec_tick;
  logic [31:0] rsp_rdata;

  always #4 clk = ~clk;

  usec_timebase i_usec_timebase (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .usec_tick(usec_tick)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [31:0]     m_cnt;
  logic [15:0]     m_cfg;
  longint unsigned m_k;
  logic            m_rspv, m_tick;
  logic [31:0]     m_rspd;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R3, R11: tick placement rule
  function automatic logic tick_rule(longint unsigned k, longint unsigned mm,
                                     longint unsigned nn);
    if (mm >= nn) return 1'b1;
    return ((k * mm) / nn) != (((k - 1) * mm) / nn);
  endfunction

  // R9: register decode
  function automatic logic [31:0] read_value(logic [7:0] a);
    if (a == 8'h10) return m_cnt;
    if (a == 8'h14) return {16'h0, m_cfg};
    return 32'h0;
  endfunction

  task automatic model_edge();
    logic acc, rd, cfgw, cntw;
    logic [31:0] rv;
    if (!rst_n) begin
      m_cnt = 0; m_cfg = 16'h000b; m_k = 0; m_rspv = 0; m_rspd = 0; m_tick = 0;
      return;
    end
    acc  = req_valid && (!m_rspv || rsp_ready);
    rd   = acc && !req_write;
    cfgw = acc && req_write && req_addr == 8'h14;
    cntw = acc && req_write && req_addr == 8'h10;
    rv   = read_value(req_addr);
    if (cfgw) begin
      m_tick = 0; m_k = 0; m_cfg = req_wdata[15:0];
    end else begin
      m_k++;
      m_tick = tick_rule(m_k, longint'(m_cfg[15:8]) + 1, longint'(m_cfg[7:0]) + 1);
    end
    m_cnt = cntw ? req_wdata : m_cnt + {31'h0, m_tick};
    if (rd) begin m_rspv = 1; m_rspd = rv; end
    else if (rsp_ready) m_rspv = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    if (rst_n) begin
      check(usec_tick == m_tick, "R3", {31'h0, usec_tick}, {31'h0, m_tick});
      check(rsp_valid == m_rspv, "R10", {31'h0, rsp_valid}, {31'h0, m_rspv});
      if (m_rspv) check(rsp_rdata == m_rspd, "R5 R9", rsp_rdata, m_rspd);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    logic got;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; rsp_ready = 1;
    forever begin
      got = req_ready;
      step();
      if (got) break;
    end
    req_valid = 0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    logic got;
    req_valid = 1; req_write = 0; req_addr = a; rsp_ready = 1;
    forever begin
      got = req_ready;
      step();
      if (got) break;
    end
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd7321));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; rsp_ready = 1;
    repeat (3) step();
    rst_n = 1;
    #0;
    check(usec_tick == 1'b0 && rsp_valid == 1'b0, "R1", {30'h0, usec_tick, rsp_valid}, 32'h0);

    // R1: reset values
    do_read(8'h14, d); check(d == 32'h0000000b, "R1", d, 32'h0000000b);
    do_read(8'h10, d); check(d == 32'h0, "R1", d, 32'h0);

    // R3: default 1/12 ratio; count after running
    repeat (40) step();

    // R2: readback masks upper bits
    do_write(8'h14, 32'hABCD045F);
    do_read(8'h14, d); check(d == 32'h0000045f, "R2", d, 32'h0000045f);

    // R8: first tick after edge k=20
    do_write(8'h14, 32'h0000045F);
    n = 0;
    for (int s = 1; s <= 40; s++) begin
      step();
      if (usec_tick && n == 0) n = s;
    end
    check(n == 20, "R8", n, 32'd20);

    // R4: 50 ticks in 960 cycles
    do_write(8'h14, 32'h0000045F);
    n = 0;
    for (int s = 0; s < 960; s++) begin
      step();
      if (usec_tick) n++;
    end
    check(n == 50, "R4", n, 32'd50);

    // R11: M >= N ticks every cycle
    do_write(8'h14, 32'h00000300);
    n = 0;
    for (int s = 0; s < 5; s++) begin
      step();
      if (usec_tick) n++;
    end
    check(n == 5, "R11", n, 32'd5);

    // R6, R7: load and wrap with 1/1
    do_write(8'h14, 32'h00000000);
    do_write(8'h10, 32'hFFFFFFFE);
    do_read(8'h10, d); check(d == 32'hFFFFFFFE, "R7", d, 32'hFFFFFFFE);
    step();
    do_read(8'h10, d); check(d == 32'h00000000, "R6", d, 32'h00000000);

    // R9: unmapped offsets
    do_write(8'h20, 32'h12345678);
    do_read(8'h20, d); check(d == 32'h0, "R9", d, 32'h0);
    do_read(8'h14, d); check(d == 32'h0, "R9", d, 32'h0);

    // R10: stalled response
    do_write(8'h14, 32'h0000000b);
    req_valid = 1; req_write = 0; req_addr = 8'h10; rsp_ready = 0;
    step();
    req_addr = 8'h14;
    for (int s = 0; s < 3; s++) begin
      step();
      check(req_ready == 1'b0, "R10", {31'h0, req_ready}, 32'h0);
    end
    rsp_ready = 1;
    step();
    req_valid = 0;
    step();

    // Random traffic
    for (int it = 0; it < 4000; it++) begin
      if (!(req_valid && !req_ready)) begin
        int op = int'($urandom_range(0, 9));
        req_valid = (op < 6);
        req_write = (op < 3);
        case ($urandom_range(0, 3))
          0: req_addr = 8'h10;
          1: req_addr = 8'h20;
          default: req_addr = 8'h14;
        endcase
        if (req_addr == 8'h14)
          req_wdata = {$urandom_range(0, 65535), 5'h0, 3'($urandom_range(0, 7)),
                       4'h0, 4'($urandom_range(0, 15))};
        else
          req_wdata = $urandom;
      end
      rsp_ready = ($urandom_range(0, 9) < 7);
      step();
    end
    req_valid = 0; rsp_ready = 1;
    repeat (2) step();
    finish_up();
  end
endmodule